// File: doc/BRIEF.md
# Pipe-Tagged Acknowledgement Payload Queue

This block keeps a few acknowledgement payloads that are waiting to go out. Each payload carries the number of the receive pipe it answers. A host loads payloads one at a time through a dedicated write-command path. That path presents a pipe number with the first byte, then one byte per valid cycle, and marks the final byte. Loading is accepted only while the device is receiving. The block stores the payload length, capped at the byte limit, next to the bytes.

When the receive side acknowledges a packet on some pipe, it raises a read request naming that pipe. The queue picks the oldest stored payload with that tag and streams it out one byte per cycle. It frees the entry after the final byte has left. Entries for other pipes keep their relative age, so first-in-first-out order holds within a pipe but not across the whole queue.

Status outputs show full, empty, which pipes have something waiting, and a sticky overflow flag. A flush input empties everything at once.

Top module: `ackpl_queue`

## Requirements
- R1: After reset `empty`=1, `full`=0, `pipe_avail`=0, `overflow`=0, `rd_valid`=0 and `rd_none`=0.
- R2: A payload whose first byte carries pipe p (0 to 5) while `rx_mode`=1 is committed at the edge that takes its `wr_last` byte, and `pipe_avail[p]` is 1 in the cycle after that edge. Reading pipe p returns the same bytes in order, one per cycle, with `rd_valid`=1, and `rd_last`=1 on the final byte only. The first byte appears in the cycle after the edge that samples `rd_req`.
- R3: At most 3 payloads are stored. A legal payload that starts while 3 are stored is discarded whole and sets `overflow`. `overflow` stays 1 until flush, and the stored entries are unchanged.
- R4: Payloads with the same pipe number are read out in the order they were committed.
- R5: A read of pipe p returns the oldest entry tagged p, whatever entries for other pipes are older. Removing it leaves the order of the remaining entries unchanged.
- R6: A read request for a pipe with no stored entry produces `rd_none`=1 for exactly one cycle, after the sampling edge, with `rd_valid`=0. Nothing is removed.
- R7: An entry stays counted in `full`, `empty` and `pipe_avail` up to and including the cycle that shows its final byte. It is released at the next edge.
- R8: Payloads whose first byte arrives while `rx_mode`=0 are dropped and do not set `overflow`.
- R9: Payloads whose first byte carries pipe 6 or 7 are dropped and do not set `overflow`. A read of pipe 6 or 7 gives `rd_none`.
- R10: `flush` held for one cycle empties every entry, ends any stream in progress and clears `overflow`. All of this takes effect at the next edge.
- R11: A payload longer than 32 bytes keeps its first 32 bytes, and its stored length is 32.
- R12: A read request made while a payload is streaming is ignored: no `rd_none` is raised and nothing is removed.
- R13: `full`=1 exactly when 3 entries are stored, and `empty`=1 exactly when none are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty the queue and clear overflow |
| rx_mode | input | 1 | Device is in receive mode; loading allowed |
| wr_valid | input | 1 | Write byte valid |
| wr_pipe | input | 3 | Pipe tag, sampled with the first byte of a payload |
| wr_data | input | 8 | Write byte |
| wr_last | input | 1 | Final byte of the payload |
| rd_req | input | 1 | Request the oldest payload for `rd_pipe` |
| rd_pipe | input | 3 | Pipe being acknowledged |
| rd_valid | output | 1 | Streamed byte valid |
| rd_data | output | 8 | Streamed byte |
| rd_last | output | 1 | Final streamed byte |
| rd_none | output | 1 | One-cycle pulse: no payload for the requested pipe |
| pipe_avail | output | 6 | Bit p set when pipe p has a stored payload |
| full | output | 1 | Three entries stored |
| empty | output | 1 | No entry stored |
| overflow | output | 1 | Sticky: a payload was refused for lack of space |

## Verification
The assertions take for granted that the write path delivers whole payloads: every started payload ends with a `wr_last` byte before a new first byte. They also assume `rd_req` is a single-cycle pulse. The bench drives payloads only through a task that always closes each one with `wr_last`. It pulses `rd_req` for exactly one cycle, except in the test that deliberately raises a second request during a stream. The flush checks assume `flush` is not held across the write of a payload the bench still expects to find, so the bench flushes only between payloads or during a read stream.

// File: rtl/ackpl_pkg.sv
package ackpl_pkg;
  localparam int PIPE_W = 3;
  typedef logic [7:0] byte_t;

  // A pipe tag is usable when it is below the number of implemented pipes.
  function automatic logic pipe_in_range(logic [PIPE_W-1:0] p, int n);
    return int'(p) < n;
  endfunction

  // Byte counter step that stops at the payload limit.
  function automatic int sat_inc(int v, int lim);
    return (v >= lim) ? lim : v + 1;
  endfunction
endpackage

// File: rtl/ackpl_fill.sv
module ackpl_fill
  import ackpl_pkg::*;
#(
  parameter int DEPTH     = 3,
  parameter int MAX_BYTES = 32,
  parameter int NUM_PIPES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              rx_mode,
  input  logic              wr_valid,
  input  logic [PIPE_W-1:0] wr_pipe,
  input  byte_t             wr_data,
  input  logic              wr_last,
  input  logic [DEPTH-1:0]  slot_valid,
  output logic              byte_we,
  output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] byte_slot,
  output logic [$clog2(MAX_BYTES)-1:0] byte_idx,
  output byte_t             byte_data,
  output logic              commit,
  output logic [PIPE_W-1:0] commit_pipe,
  output logic [$clog2(MAX_BYTES+1)-1:0] commit_len,
  output logic              reject_evt
);
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LEN_W  = $clog2(MAX_BYTES + 1);
  localparam int IDX_W  = $clog2(MAX_BYTES);

  logic              busy, keep_q;
  logic [SLOT_W-1:0] slot_q, free_idx, cur_slot;
  logic [PIPE_W-1:0] pipe_q;
  logic [LEN_W-1:0]  cnt_q, cur_cnt, next_cnt;
  logic              free_found, legal, cur_keep;

  // Lowest-numbered empty slot.
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!slot_valid[i]) begin
        free_found = 1'b1;
        free_idx   = SLOT_W'(i);
      end
    end
  end

  assign legal       = rx_mode && pipe_in_range(wr_pipe, NUM_PIPES);
  assign cur_keep    = busy ? keep_q : (legal && free_found);
  assign cur_slot    = busy ? slot_q : free_idx;
  assign commit_pipe = busy ? pipe_q : wr_pipe;
  assign cur_cnt     = busy ? cnt_q : '0;
  assign next_cnt    = LEN_W'(sat_inc(int'(cur_cnt), MAX_BYTES));

  assign reject_evt = wr_valid && !busy && legal && !free_found && !flush;
  assign byte_we    = wr_valid && cur_keep && !flush && (int'(cur_cnt) < MAX_BYTES);
  assign byte_slot  = cur_slot;
  assign byte_idx   = IDX_W'(cur_cnt);
  assign byte_data  = wr_data;
  assign commit     = wr_valid && wr_last && cur_keep && !flush;
  assign commit_len = next_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      keep_q <= 1'b0;
      slot_q <= '0;
      pipe_q <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      busy <= 1'b0;
    end else if (wr_valid) begin
      busy   <= !wr_last;
      keep_q <= cur_keep;
      slot_q <= cur_slot;
      pipe_q <= commit_pipe;
      cnt_q  <= next_cnt;
    end
  end
endmodule

// File: rtl/ackpl_slots.sv
module ackpl_slots
  import ackpl_pkg::*;
#(
  parameter int DEPTH     = 3,
  parameter int MAX_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              byte_we,
  input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] byte_slot,
  input  logic [$clog2(MAX_BYTES)-1:0] byte_idx,
  input  byte_t             byte_data,
  input  logic              commit,
  input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] commit_slot,
  input  logic [PIPE_W-1:0] commit_pipe,
  input  logic [$clog2(MAX_BYTES+1)-1:0] commit_len,
  input  logic              free,
  input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] free_slot,
  input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] rd_slot,
  input  logic [$clog2(MAX_BYTES)-1:0] rd_idx,
  output logic [DEPTH-1:0]  slot_valid,
  output logic [DEPTH-1:0][PIPE_W-1:0] slot_pipe,
  output logic [DEPTH-1:0][$clog2(MAX_BYTES+1)-1:0] slot_len,
  output logic [DEPTH-1:0][((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] slot_rank,
  output byte_t             rd_byte
);
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  byte_t             mem [DEPTH][MAX_BYTES];
  logic [DEPTH-1:0]  free_mask;
  logic [SLOT_W-1:0] new_rank;

  // Rank = number of entries older than this one; 0 is the oldest.
  assign free_mask = free ? (DEPTH'(1) << free_slot) : '0;
  assign new_rank  = SLOT_W'($countones(slot_valid & ~free_mask));
  assign rd_byte   = mem[rd_slot][rd_idx];

  always_ff @(posedge clk) begin
    if (byte_we) mem[byte_slot][byte_idx] <= byte_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_valid <= '0;
      slot_pipe  <= '0;
      slot_len   <= '0;
      slot_rank  <= '0;
    end else if (flush) begin
      slot_valid <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (free_mask[i]) slot_valid[i] <= 1'b0;
        else if (free && slot_valid[i] && slot_rank[i] > slot_rank[free_slot])
          slot_rank[i] <= slot_rank[i] - 1'b1;
      end
      if (commit) begin
        slot_valid[commit_slot] <= 1'b1;
        slot_pipe[commit_slot]  <= commit_pipe;
        slot_len[commit_slot]   <= commit_len;
        slot_rank[commit_slot]  <= new_rank;
      end
    end
  end
endmodule

// File: rtl/ackpl_drain.sv
module ackpl_drain
  import ackpl_pkg::*;
#(
  parameter int DEPTH     = 3,
  parameter int MAX_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              rd_req,
  input  logic [PIPE_W-1:0] rd_pipe,
  input  logic [DEPTH-1:0]  slot_valid,
  input  logic [DEPTH-1:0][PIPE_W-1:0] slot_pipe,
  input  logic [DEPTH-1:0][$clog2(MAX_BYTES+1)-1:0] slot_len,
  input  logic [DEPTH-1:0][((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] slot_rank,
  output logic              rd_active,
  output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] rd_slot,
  output logic [$clog2(MAX_BYTES)-1:0] rd_idx,
  output logic              rd_last,
  output logic              rd_none,
  output logic              free
);
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LEN_W  = $clog2(MAX_BYTES + 1);

  logic              hit;
  logic [SLOT_W-1:0] pick, best;

  // Oldest stored entry carrying the requested tag.
  always_comb begin
    hit  = 1'b0;
    pick = '0;
    best = '1;
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_valid[i] && slot_pipe[i] == rd_pipe && (!hit || slot_rank[i] < best)) begin
        hit  = 1'b1;
        pick = SLOT_W'(i);
        best = slot_rank[i];
      end
    end
  end

  assign rd_last = rd_active && (LEN_W'(rd_idx) + LEN_W'(1) == slot_len[rd_slot]);
  assign free    = rd_last && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_active <= 1'b0;
      rd_slot   <= '0;
      rd_idx    <= '0;
      rd_none   <= 1'b0;
    end else if (flush) begin
      rd_active <= 1'b0;
      rd_none   <= 1'b0;
    end else begin
      rd_none <= 1'b0;
      if (rd_active) begin
        if (rd_last) rd_active <= 1'b0;
        else rd_idx <= rd_idx + 1'b1;
      end else if (rd_req) begin
        if (hit) begin
          rd_active <= 1'b1;
          rd_slot   <= pick;
          rd_idx    <= '0;
        end else begin
          rd_none <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ackpl_queue.sv
module ackpl_queue
  import ackpl_pkg::*;
#(
  parameter int DEPTH     = 3,
  parameter int MAX_BYTES = 32,
  parameter int NUM_PIPES = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 rx_mode,
  input  logic                 wr_valid,
  input  logic [2:0]           wr_pipe,
  input  logic [7:0]           wr_data,
  input  logic                 wr_last,
  input  logic                 rd_req,
  input  logic [2:0]           rd_pipe,
  output logic                 rd_valid,
  output logic [7:0]           rd_data,
  output logic                 rd_last,
  output logic                 rd_none,
  output logic [NUM_PIPES-1:0] pipe_avail,
  output logic                 full,
  output logic                 empty,
  output logic                 overflow
);
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LEN_W  = $clog2(MAX_BYTES + 1);
  localparam int IDX_W  = $clog2(MAX_BYTES);

  // Named internal events, also observed by the bound checker.
  logic                   byte_we, commit, reject_evt, free;
  logic [SLOT_W-1:0]      byte_slot, rd_slot;
  logic [IDX_W-1:0]       byte_idx, rd_idx;
  byte_t                  byte_data;
  logic [PIPE_W-1:0]      commit_pipe;
  logic [LEN_W-1:0]       commit_len;
  logic [DEPTH-1:0]       slot_valid;
  logic [DEPTH-1:0][PIPE_W-1:0] slot_pipe;
  logic [DEPTH-1:0][LEN_W-1:0]  slot_len;
  logic [DEPTH-1:0][SLOT_W-1:0] slot_rank;

  ackpl_fill #(.DEPTH(DEPTH), .MAX_BYTES(MAX_BYTES), .NUM_PIPES(NUM_PIPES)) u_fill (
    .clk, .rst_n, .flush, .rx_mode, .wr_valid, .wr_pipe, .wr_data, .wr_last,
    .slot_valid, .byte_we, .byte_slot, .byte_idx, .byte_data,
    .commit, .commit_pipe, .commit_len, .reject_evt
  );

  ackpl_slots #(.DEPTH(DEPTH), .MAX_BYTES(MAX_BYTES)) u_slots (
    .clk, .rst_n, .flush, .byte_we, .byte_slot, .byte_idx, .byte_data,
    .commit, .commit_slot(byte_slot), .commit_pipe, .commit_len,
    .free, .free_slot(rd_slot), .rd_slot, .rd_idx,
    .slot_valid, .slot_pipe, .slot_len, .slot_rank, .rd_byte(rd_data)
  );

  ackpl_drain #(.DEPTH(DEPTH), .MAX_BYTES(MAX_BYTES)) u_drain (
    .clk, .rst_n, .flush, .rd_req, .rd_pipe,
    .slot_valid, .slot_pipe, .slot_len, .slot_rank,
    .rd_active(rd_valid), .rd_slot, .rd_idx, .rd_last, .rd_none, .free
  );

  always_comb begin
    pipe_avail = '0;
    for (int p = 0; p < NUM_PIPES; p++)
      for (int i = 0; i < DEPTH; i++)
        if (slot_valid[i] && int'(slot_pipe[i]) == p) pipe_avail[p] = 1'b1;
  end

  assign full  = &slot_valid;
  assign empty = ~|slot_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          overflow <= 1'b0;
    else if (flush)      overflow <= 1'b0;
    else if (reject_evt) overflow <= 1'b1;
  end
endmodule

// File: rtl/ackpl_queue_chk.sv
module ackpl_queue_chk #(
  parameter int DEPTH     = 3,
  parameter int NUM_PIPES = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 flush,
  input logic                 overflow,
  input logic                 empty,
  input logic                 full,
  input logic [NUM_PIPES-1:0] pipe_avail,
  input logic                 rd_valid,
  input logic                 rd_last,
  input logic                 rd_none,
  input logic [DEPTH-1:0]     slot_valid,
  input logic                 commit,
  input logic [2:0]           commit_pipe,
  input logic                 reject_evt
);
  p_overflow_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt && !flush |=> overflow);
  p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !flush |=> overflow);
  p_none_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_none |-> !rd_valid);
  p_free_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_last && !flush && !commit |=>
      $countones(slot_valid) + 1 == $countones($past(slot_valid)));
  p_pipe_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> int'(commit_pipe) < NUM_PIPES);
  p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty && !overflow && !rd_valid && !rd_none);
  p_stream_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_last && !flush |=> rd_valid);
  p_empty_no_avail_r13: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> pipe_avail == '0);
  p_full_not_empty_r13: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !empty);
endmodule

bind ackpl_queue ackpl_queue_chk #(.DEPTH(DEPTH), .NUM_PIPES(NUM_PIPES)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .overflow(overflow), .empty(empty),
  .full(full), .pipe_avail(pipe_avail), .rd_valid(rd_valid), .rd_last(rd_last),
  .rd_none(rd_none), .slot_valid(slot_valid), .commit(commit),
  .commit_pipe(commit_pipe), .reject_evt(reject_evt)
);

// File: tb/test_ackpl_queue.sv
module test_ackpl_queue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 0, rx_mode = 1, wr_valid = 0, wr_last = 0, rd_req = 0;
  logic [2:0] wr_pipe = 0, rd_pipe = 0;
  logic [7:0] wr_data = 0;
  logic rd_valid, rd_last, rd_none, full, empty, overflow;
  logic [7:0] rd_data;
  logic [5:0] pipe_avail;

  int checks = 0, fails = 0;
  bit finished = 0;

  // Reference queue, oldest first.
  int m_pipe[3], m_len[3], m_seed[3];
  int m_n = 0;
  bit m_ovf = 0;

  always #2 clk = ~clk;

  ackpl_queue i_ackpl_queue (
    .clk, .rst_n, .flush, .rx_mode, .wr_valid, .wr_pipe, .wr_data, .wr_last,
    .rd_req, .rd_pipe, .rd_valid, .rd_data, .rd_last, .rd_none,
    .pipe_avail, .full, .empty, .overflow
  );

  function automatic int byte_of(int seed, int i);
    return (seed * 37 + i * 11 + 5) & 255;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic status(input string req);
    int av;
    av = 0;
    for (int i = 0; i < m_n; i++) av |= (1 << m_pipe[i]);
    chk(int'(pipe_avail) == av, {req, " avail"}, pipe_avail, av);
    chk(empty == (m_n == 0) && full == (m_n == 3), {req, " R13 empty/full"},
        {empty, full}, {(m_n == 0), (m_n == 3)});
    chk(overflow == m_ovf, {req, " overflow"}, overflow, m_ovf);
  endtask

  task automatic write_pl(input int pipe, input int len, input int seed, input bit rx);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      wr_valid = 1; wr_pipe = 3'(pipe); wr_data = 8'(byte_of(seed, i));
      wr_last = (i == len - 1); rx_mode = rx;
    end
    @(negedge clk);
    wr_valid = 0; wr_last = 0; rx_mode = 1;
    if (rx && pipe < 6) begin
      if (m_n < 3) begin
        m_pipe[m_n] = pipe; m_len[m_n] = (len > 32) ? 32 : len; m_seed[m_n] = seed;
        m_n++;
      end else m_ovf = 1;
    end
  endtask

  task automatic drop_entry(input int k);
    for (int i = k; i < m_n - 1; i++) begin
      m_pipe[i] = m_pipe[i+1]; m_len[i] = m_len[i+1]; m_seed[i] = m_seed[i+1];
    end
    m_n--;
  endtask

  task automatic rd_check(input int pipe, input string req);
    int k;
    k = -1;
    for (int i = m_n - 1; i >= 0; i--) if (m_pipe[i] == pipe) k = i;
    @(negedge clk);
    rd_req = 1; rd_pipe = 3'(pipe);
    @(negedge clk);
    rd_req = 0;
    if (k < 0) begin
      chk(rd_none == 1 && rd_valid == 0, {req, " R6 none pulse"}, {rd_none, rd_valid}, 2);
      @(negedge clk);
      chk(rd_none == 0, {req, " R6 single pulse"}, rd_none, 0);
    end else begin
      for (int i = 0; i < m_len[k]; i++) begin
        chk(rd_valid && rd_data == 8'(byte_of(m_seed[k], i)) && rd_last == (i == m_len[k] - 1),
            {req, " R2 byte"}, rd_data, byte_of(m_seed[k], i));
        if (i == m_len[k] - 1)
          chk(pipe_avail[pipe] == 1, {req, " R7 held to last"}, pipe_avail[pipe], 1);
        @(negedge clk);
      end
      chk(rd_valid == 0, {req, " R2 stream end"}, rd_valid, 0);
      drop_entry(k);
    end
    status(req);
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    m_n = 0; m_ovf = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rd_valid == 0 && rd_none == 0, "R1 reset stream", rd_valid, 0);
    status("R1 reset");

    // R2 / R9 / R11: every pipe tag against every length up to one past the limit.
    for (int p = 0; p < 8; p++)
      for (int len = 1; len <= 33; len++) begin
        write_pl(p, len, p * 40 + len, 1);
        status(p < 6 ? "R2 after write" : "R9 bad pipe");
        rd_check(p, len > 32 ? "R11 long" : (p < 6 ? "R2 read" : "R9 bad pipe read"));
      end

    // R8: not in receive mode.
    write_pl(1, 4, 7, 0);
    status("R8 rx off");
    rd_check(1, "R8 rx off read");

    // R4 / R5 / R6: all tag patterns over three entries, reads in mixed order.
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++) begin
          int seq[9];
          seq = '{0, 1, 2, 1, 0, 2, 0, 1, 2};
          do_flush();
          write_pl(a, 1 + (a + b + c) % 4, 10 + a, 1);
          write_pl(b, 1 + (b + c) % 4, 20 + b, 1);
          write_pl(c, 1 + c % 4, 30 + c, 1);
          status("R13 three stored");
          foreach (seq[j]) rd_check(seq[j], "R4 R5 order");
        end

    // R3: overflow on a fourth legal payload, entries untouched, flag sticky.
    do_flush();
    write_pl(0, 3, 50, 1);
    write_pl(1, 2, 51, 1);
    write_pl(0, 5, 52, 1);
    write_pl(2, 4, 53, 1);
    status("R3 overflow");
    write_pl(7, 2, 54, 1);
    status("R3 bad pipe when full");
    rd_check(0, "R3 kept");
    rd_check(2, "R3 dropped");
    status("R3 sticky");
    do_flush();
    status("R10 flush clears");

    // R12: request during a stream is ignored.
    write_pl(0, 3, 60, 1);
    write_pl(1, 2, 61, 1);
    @(negedge clk); rd_req = 1; rd_pipe = 0;
    @(negedge clk); rd_req = 1; rd_pipe = 1;
    chk(rd_valid && rd_data == 8'(byte_of(60, 0)), "R12 byte0", rd_data, byte_of(60, 0));
    @(negedge clk); rd_req = 0;
    chk(rd_valid && rd_data == 8'(byte_of(60, 1)) && !rd_none, "R12 byte1", rd_data, byte_of(60, 1));
    @(negedge clk);
    chk(rd_valid && rd_last && rd_data == 8'(byte_of(60, 2)), "R12 byte2", rd_data, byte_of(60, 2));
    @(negedge clk);
    chk(!rd_valid && !rd_none, "R12 no second stream", {rd_valid, rd_none}, 0);
    drop_entry(0);
    status("R12 entry kept");
    rd_check(1, "R12 later read");

    // R10: flush in the middle of a stream.
    write_pl(3, 5, 70, 1);
    write_pl(4, 2, 71, 1);
    @(negedge clk); rd_req = 1; rd_pipe = 3;
    @(negedge clk); rd_req = 0;
    chk(rd_valid == 1, "R10 stream started", rd_valid, 1);
    flush = 1;
    @(negedge clk); flush = 0;
    m_n = 0; m_ovf = 0;
    chk(rd_valid == 0, "R10 stream aborted", rd_valid, 0);
    status("R10 mid-stream flush");
    rd_check(4, "R10 nothing left");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule